// File: doc/BRIEF.md
# Table-Based Sine Excitation Generator

This block produces the digital side of a sinusoidal excitation source. Every step it outputs one 8-bit code from a stored waveform of 200 samples per period. The codes go to an external DAC. Steps come from an integer divider of the system clock, and the divider value is taken from a small table of eight excitation frequencies: 50, 60, 100, 200, 500, 1000, 1500 and 2000 Hz. With a 24 MHz clock every ratio is an exact integer.

The block also drives three timing signals for the rest of the measurement chain:
- a marker that is high across the last two samples of each period, so a synchronous detector can align its reference;
- a square-wave clock at half the step rate, which is 100 times the excitation frequency, so an external switched-capacitor bandpass filter tracks the excitation without software help;
- the current table position, for phase-shifting logic elsewhere.

Two waveforms are stored, a sine and a triangle, both centred on mid-scale. A new waveform selection or a new frequency selection only takes effect when the period wraps. The waveform therefore never jumps part-way through a cycle.

The sample output is a stream without back-pressure. `dac_valid` pulses for one clock when a new code is presented, and the consumer must take every code. The code is held between pulses.

Top module: `sine_exciter`

## Requirements
- R1: While `rst_n` is low, and until the first step after reset, `phase_idx` is 0, `dac_code` is 128, `sync_out` and `filt_clk` are 0, and `dac_valid` is 0.
- R2: Each `dac_valid` pulse comes with `phase_idx` one greater than before. The value 199 is followed by 0, and `phase_idx` never exceeds 199.
- R3: Consecutive `dac_valid` pulses are exactly D clock cycles apart. D = CLK_HZ / (200 × F), and F is taken from `rate_sel` as follows: index 0 → 50, 1 → 60, 2 → 100, 3 → 200, 4 → 500, 5 → 1000, 6 → 1500, 7 → 2000 Hz. D must be at least 2.
- R4: With waveform 0 in use (`wave_sel` = 0), the code at position k is defined as follows. Let j = k for k < 100 and j = k − 100 otherwise. Let s = (127·16·j·(100−j)) / (5·100·100 − 4·j·(100−j)), truncated. The code is 128 + s for k < 100 and 128 − s otherwise. Position 0 gives 128.
- R5: With waveform 1 in use (`wave_sel` = 1), the code at position k is a triangle computed with signed division truncating toward zero:
  - 128 + 127·k/50 for k < 50;
  - 128 + 127·(100−k)/50 for 50 ≤ k < 150;
  - 128 − 127·(200−k)/50 otherwise.
- R6: A change of `wave_sel` alters the codes only from the sample at position 0 after the next wrap. The value sampled on the clock of that wrap is the one used.
- R7: A change of `rate_sel` alters the pulse spacing only from the interval that starts at the next position-0 sample. The interval that ends on the position-0 sample still uses the old D.
- R8: `sync_out` is high exactly while `phase_idx` is 198 or 199, which spans two steps at the end of each period.
- R9: `filt_clk` toggles on every step, so its period is two steps (100 × F). It always equals bit 0 of `phase_idx`.
- R10: After reset the divider runs at rate index 5 (1000 Hz) until the first wrap, whatever `rate_sel` is.
- R11: `dac_valid` is never high on two consecutive cycles. `dac_code` and `phase_idx` change only on cycles where `dac_valid` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rate_sel | input | 3 | Excitation frequency index, applied at the next wrap |
| wave_sel | input | 1 | Waveform table index, applied at the next wrap |
| dac_code | output | CODE_W (8) | Current waveform code, mid-scale centred |
| dac_valid | output | 1 | One-cycle pulse marking a new code |
| phase_idx | output | $clog2(STEPS) (8) | Table position 0 to 199 |
| sync_out | output | 1 | End-of-period marker, high for the last two steps |
| filt_clk | output | 1 | Filter-tracking clock at half the step rate |

## Verification
The properties assume that the clock-to-step ratio of every rate index is at least two. They also assume that reset is held for at least one clock. `rate_sel` and `wave_sel` are otherwise unconstrained.

The bench keeps every divider at three or more cycles by building the block with a 1.2 MHz clock parameter. It changes the select inputs on falling edges, both in mid-period and right after a wrap, so that deferred and immediate-boundary cases both occur. It sweeps all eight rate indices and both waveforms across full periods.

// File: rtl/sinex_pkg.sv
package sinex_pkg;

  localparam int NUM_RATES = 8;

  // Excitation frequency in Hz for each rate index.
  function automatic int rate_hz(input int idx);
    int hz;
    if (idx == 0)      hz = 50;
    else if (idx == 1) hz = 60;
    else if (idx == 2) hz = 100;
    else if (idx == 3) hz = 200;
    else if (idx == 4) hz = 500;
    else if (idx == 5) hz = 1000;
    else if (idx == 6) hz = 1500;
    else               hz = 2000;
    return hz;
  endfunction

  // System clocks per table step for a rate index.
  function automatic int step_div(input int clk_hz, input int steps, input int idx);
    return clk_hz / (steps * rate_hz(idx));
  endfunction

  // Rational half-wave sine approximation, offset to mid-scale.
  function automatic int sine_val(input int k, input int steps, input int mid);
    int half, j, num, den, mag;
    half = steps / 2;
    j    = (k < half) ? k : k - half;
    num  = (mid - 1) * 16 * j * (half - j);
    den  = 5 * half * half - 4 * j * (half - j);
    mag  = num / den;
    return (k < half) ? mid + mag : mid - mag;
  endfunction

  // Triangle with the same zero crossings as the sine.
  function automatic int tri_val(input int k, input int steps, input int mid);
    int q, amp, r;
    q   = steps / 4;
    amp = mid - 1;
    if (k < q)          r = mid + (amp * k) / q;
    else if (k < 3 * q) r = mid + (amp * (2 * q - k)) / q;
    else                r = mid - (amp * (steps - k)) / q;
    return r;
  endfunction

endpackage

// File: rtl/sinex_rate_div.sv
module sinex_rate_div
  import sinex_pkg::*;
#(
  parameter int CLK_HZ  = 24_000_000,
  parameter int STEPS   = 200,
  parameter int DIV_W   = 12,
  parameter int RST_IDX = 5
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       load,
  input  logic [2:0] rate_idx,
  output logic       step
);

  localparam logic [DIV_W-1:0] RST_DIV = DIV_W'(step_div(CLK_HZ, STEPS, RST_IDX));

  logic [DIV_W-1:0] div_tbl [NUM_RATES];
  logic [DIV_W-1:0] div_val;
  logic [DIV_W-1:0] cnt;

  for (genvar g = 0; g < NUM_RATES; g++) begin : g_div
    assign div_tbl[g] = DIV_W'(step_div(CLK_HZ, STEPS, g));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt     <= '0;
      step    <= 1'b0;
      div_val <= RST_DIV;
    end else begin
      if (cnt == div_val - DIV_W'(1)) begin
        cnt  <= '0;
        step <= 1'b1;
      end else begin
        cnt  <= cnt + DIV_W'(1);
        step <= 1'b0;
      end
      if (load) div_val <= div_tbl[rate_idx];
    end
  end

endmodule

// File: rtl/sinex_phase_seq.sv
module sinex_phase_seq #(
  parameter int STEPS = 200,
  parameter int PH_W  = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            step,
  output logic [PH_W-1:0] phase,
  output logic [PH_W-1:0] nxt,
  output logic            wrap,
  output logic            valid,
  output logic            sync,
  output logic            filt
);

  logic at_end;

  assign at_end = (phase == PH_W'(STEPS - 1));
  assign wrap   = step && at_end;
  assign nxt    = at_end ? '0 : phase + PH_W'(1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase <= '0;
      valid <= 1'b0;
      sync  <= 1'b0;
      filt  <= 1'b0;
    end else begin
      valid <= step;
      if (step) begin
        phase <= nxt;
        sync  <= (nxt >= PH_W'(STEPS - 2));
        filt  <= ~filt;
      end
    end
  end

endmodule

// File: rtl/sinex_wave_rom.sv
module sinex_wave_rom
  import sinex_pkg::*;
#(
  parameter int STEPS  = 200,
  parameter int PH_W   = 8,
  parameter int CODE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              step,
  input  logic              wrap,
  input  logic              wave_req,
  input  logic [PH_W-1:0]   nxt,
  output logic [CODE_W-1:0] code
);

  localparam int MID = 1 << (CODE_W - 1);

  logic [CODE_W-1:0] tbl_sine [STEPS];
  logic [CODE_W-1:0] tbl_tri  [STEPS];
  logic              cur_wave;
  logic              wave_eff;

  for (genvar g = 0; g < STEPS; g++) begin : g_tbl
    assign tbl_sine[g] = CODE_W'(sine_val(g, STEPS, MID));
    assign tbl_tri[g]  = CODE_W'(tri_val(g, STEPS, MID));
  end

  assign wave_eff = wrap ? wave_req : cur_wave;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cur_wave <= 1'b0;
      code     <= CODE_W'(MID);
    end else begin
      if (wrap) cur_wave <= wave_req;
      if (step) code <= wave_eff ? tbl_tri[nxt] : tbl_sine[nxt];
    end
  end

endmodule

// File: rtl/sine_exciter.sv
module sine_exciter
  import sinex_pkg::*;
#(
  parameter int CLK_HZ   = 24_000_000,
  parameter int STEPS    = 200,
  parameter int CODE_W   = 8,
  parameter int RST_RATE = 5,
  localparam int PH_W    = $clog2(STEPS),
  localparam int DIV_W   = $clog2(step_div(CLK_HZ, STEPS, 0) + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [2:0]        rate_sel,
  input  logic              wave_sel,
  output logic [CODE_W-1:0] dac_code,
  output logic              dac_valid,
  output logic [PH_W-1:0]   phase_idx,
  output logic              sync_out,
  output logic              filt_clk
);

  logic            step;
  logic            wrap;
  logic [PH_W-1:0] nxt;

  sinex_rate_div #(
    .CLK_HZ(CLK_HZ), .STEPS(STEPS), .DIV_W(DIV_W), .RST_IDX(RST_RATE)
  ) u_div (
    .clk(clk), .rst_n(rst_n), .load(wrap), .rate_idx(rate_sel), .step(step)
  );

  sinex_phase_seq #(.STEPS(STEPS), .PH_W(PH_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .step(step), .phase(phase_idx), .nxt(nxt),
    .wrap(wrap), .valid(dac_valid), .sync(sync_out), .filt(filt_clk)
  );

  sinex_wave_rom #(.STEPS(STEPS), .PH_W(PH_W), .CODE_W(CODE_W)) u_rom (
    .clk(clk), .rst_n(rst_n), .step(step), .wrap(wrap), .wave_req(wave_sel),
    .nxt(nxt), .code(dac_code)
  );

endmodule

// File: rtl/sinex_chk.sv
module sinex_chk #(
  parameter int STEPS  = 200,
  parameter int CODE_W = 8,
  parameter int PH_W   = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic [CODE_W-1:0] dac_code,
  input logic              dac_valid,
  input logic [PH_W-1:0]   phase_idx,
  input logic              sync_out,
  input logic              filt_clk
);

  localparam int MID = 1 << (CODE_W - 1);

  AST_PHASE_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    int'(phase_idx) < STEPS);  // R2

  AST_PHASE_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
    dac_valid |-> int'(phase_idx) ==
      ((int'($past(phase_idx)) == STEPS - 1) ? 0 : int'($past(phase_idx)) + 1));  // R2

  AST_HOLD_BETWEEN: assert property (@(posedge clk) disable iff (!rst_n)
    !dac_valid |-> ($stable(phase_idx) && $stable(dac_code)));  // R11

  AST_VALID_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    dac_valid |=> !dac_valid);  // R11

  AST_SYNC_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
    sync_out == (int'(phase_idx) >= STEPS - 2));  // R8

  AST_FILT_PARITY: assert property (@(posedge clk) disable iff (!rst_n)
    filt_clk == phase_idx[0]);  // R9

  AST_ORIGIN_MID: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_idx == '0) |-> (int'(dac_code) == MID));  // R4

endmodule

bind sine_exciter sinex_chk #(.STEPS(STEPS), .CODE_W(CODE_W), .PH_W(PH_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .dac_code(dac_code), .dac_valid(dac_valid),
  .phase_idx(phase_idx), .sync_out(sync_out), .filt_clk(filt_clk)
);

// File: tb/sine_exciter_tb.sv
module sine_exciter_tb;

  localparam int CLK_PERIOD = 10;
  localparam int TB_CLK_HZ  = 1_200_000;
  localparam int N          = 200;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] rate_sel = 3'd5;
  logic       wave_sel = 1'b0;
  logic [7:0] dac_code;
  logic       dac_valid;
  logic [7:0] phase_idx;
  logic       sync_out;
  logic       filt_clk;

  int tests = 0, fails = 0, cyc = 0;
  int e_phase = 0, e_wave = 0, e_div = 0, last_cyc = 0;
  int cur_r = 5, cur_w = 0;
  bit first = 1'b1, pend_w = 1'b0, pend_r = 1'b0, in_rst_period = 1'b1, done = 1'b0;

  sine_exciter #(.CLK_HZ(TB_CLK_HZ)) u_dut (
    .clk(clk), .rst_n(rst_n), .rate_sel(rate_sel), .wave_sel(wave_sel),
    .dac_code(dac_code), .dac_valid(dac_valid), .phase_idx(phase_idx),
    .sync_out(sync_out), .filt_clk(filt_clk)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  function automatic int hz_of(input int i);
    int t [8] = '{50, 60, 100, 200, 500, 1000, 1500, 2000};
    return t[i];
  endfunction

  function automatic int div_of(input int i);
    return TB_CLK_HZ / (N * hz_of(i));
  endfunction

  function automatic int ref_code(input int k, input int w);
    int j, s;
    if (w == 0) begin
      j = (k < 100) ? k : k - 100;
      s = (127 * 16 * j * (100 - j)) / (50000 - 4 * j * (100 - j));
      return (k < 100) ? 128 + s : 128 - s;
    end
    if (k < 50)  return 128 + (127 * k) / 50;
    if (k < 150) return 128 + (127 * (100 - k)) / 50;
    return 128 - (127 * (200 - k)) / 50;
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  endtask

  // Wait for the next sample and check it against the model.
  task automatic next_sample();
    int sp, held_bad;
    held_bad = 0;
    @(negedge clk);
    while (!dac_valid) begin
      if (int'(phase_idx) != e_phase) held_bad = 1;
      @(negedge clk);
    end
    check(held_bad == 0, "R11 hold", held_bad, 0);
    sp = cyc - last_cyc;
    last_cyc = cyc;
    e_phase = (e_phase + 1) % N;
    if (!first)
      check(sp == e_div, pend_r ? "R7 deferred rate" : (in_rst_period ? "R10 reset rate" : "R3 spacing"),
            sp, e_div);
    first = 1'b0;
    if (e_phase == 0) begin
      e_wave = cur_w;
      pend_w = 1'b0;
    end
    check(int'(phase_idx) == e_phase, "R2 phase", phase_idx, e_phase);
    check(int'(dac_code) == ref_code(e_phase, e_wave),
          pend_w ? "R6 deferred wave" : (e_wave == 0 ? "R4 sine" : "R5 triangle"),
          dac_code, ref_code(e_phase, e_wave));
    check(sync_out == (e_phase >= 198), "R8 sync", sync_out, e_phase >= 198);
    check(filt_clk == e_phase[0], "R9 filt", filt_clk, e_phase % 2);
    if (e_phase == 0) begin
      e_div = div_of(cur_r);
      pend_r = 1'b0;
      in_rst_period = 1'b0;
    end
  endtask

  task automatic run(input int n);
    for (int i = 0; i < n; i++) next_sample();
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    check(1'b0, "watchdog", cyc, 0);
    finish_run();
  end

  initial begin
    int seq [6] = '{7, 4, 3, 2, 1, 0};
    rate_sel = 3'd2;   // R10: must be ignored until the first wrap
    cur_r    = 2;
    e_div    = div_of(5);
    repeat (3) @(negedge clk);
    check(phase_idx == 8'd0, "R1 phase", phase_idx, 0);
    check(dac_code == 8'd128, "R1 code", dac_code, 128);
    check(!sync_out && !filt_clk, "R1 sync/filt", {sync_out, filt_clk}, 0);
    check(!dac_valid, "R1 valid", dac_valid, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(phase_idx == 8'd0 && dac_code == 8'd128, "R1 hold after release", dac_code, 128);
    run(N);                       // first period at reset rate, wrap picks index 2
    rate_sel = 3'd5; cur_r = 5;   // aligned with the boundary just passed
    run(N);
    run(50);
    wave_sel = 1'b1; cur_w = 1; pend_w = 1'b1;
    rate_sel = 3'd6; cur_r = 6; pend_r = 1'b1;
    run(150);                     // still sine at the old rate until the wrap
    run(N);                       // triangle at the new rate
    for (int i = 0; i < 6; i++) begin
      rate_sel = 3'(seq[i]); cur_r = seq[i];
      if (i == 3) begin wave_sel = 1'b0; cur_w = 0; end
      run(N);
    end
    run(10);
    finish_run();
  end

endmodule